// File: doc/BRIEF.md
# Multi-Size AES Key Expander

This block turns an AES cipher key of 128, 192 or 256 bits into the complete sequence of round-key words and streams it out two 32-bit words per clock. A single start pulse latches the key and its size code. The block then emits the original key words, followed by every derived word, without gaps until the schedule is complete. It flags the final pair with a one-cycle done pulse.

Internally a history of the eight most recent words feeds a two-word combiner. The first word of each pair XORs the word Nk places back with a transformed copy of the newest word. The second word XORs the word Nk-1 places back with the first word. A small sequencer decides on each cycle whether the transform is the identity, a byte rotate followed by byte substitution and the round constant, or, for 256-bit keys only, substitution alone. Round-key storage and the cipher datapath belong to other blocks.

Top module: `aes_key_expander`

## Requirements
- R1: After reset, with no start, `kw_valid` and `kx_done` are both low.
- R2: `key_size` codes are 00 for 128, 01 for 192 and 10 for 256 bits. Key word j is `key_in[255-32j -: 32]`, so a shorter key occupies the upper bits. The first Nk/2 pairs emitted are the key words in order, with the lower-indexed word in `kw_pair[63:32]`.
- R3: A start accepted at one clock edge gives a valid pair after the second following edge. Pairs then arrive on consecutive cycles with no gap until the last one.
- R4: With a 128-bit key, exactly 22 pairs (44 words) are produced, matching the standard schedule. The round constant starts at 0x01 and is doubled in GF(2^8) with reduction 0x1B after each use.
- R5: With a 192-bit key, exactly 26 pairs (52 words) are produced, matching the standard schedule. Rotate, substitution and round constant are applied on every third pair after the key.
- R6: With a 256-bit key, exactly 30 pairs (60 words) are produced, matching the standard schedule. This includes the substitution-only step on words whose index is 4 modulo 8.
- R7: `kx_done` is high for exactly one cycle, together with the last valid pair.
- R8: A start seen while an expansion is in progress has no effect. The running sequence continues unchanged.
- R9: A start with the reserved size code 11 is ignored, and no output is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin expansion of `key_in` when idle |
| key_size | input | 2 | Key length code (00/01/10, 11 reserved) |
| key_in | input | 256 | Cipher key, word 0 in the top 32 bits |
| kw_pair | output | 64 | Two schedule words, lower index in upper half |
| kw_valid | output | 1 | `kw_pair` holds a schedule pair |
| kx_done | output | 1 | Last pair of the schedule is on `kw_pair` |

## Verification
The hardest situation to reach is a start pulse that lands in the middle of a running expansion, for example on a 256-bit schedule at the point where the substitution-only step alternates with the full step. The stimulus raises start with a different size code partway through several runs. It then checks that every later pair still matches the original size's reference schedule. Each size is swept over several key patterns, including the published example keys with their known final words. The reserved size code is issued from idle, and a normal run follows it directly.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  typedef enum logic [1:0] {
    KS_128  = 2'b00,
    KS_192  = 2'b01,
    KS_256  = 2'b10,
    KS_RSVD = 2'b11
  } ksize_e;

  // GF(2^8) multiply, reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int n = 0; n < 8; n++) begin
      if (b[n]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] xtime8(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  // Substitution: multiplicative inverse as a^254, then affine map
  function automatic logic [7:0] sbox8(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul8(sq, sq);
      inv = gf_mul8(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_kx_subword.sv
module aes_kx_subword #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] w_in,
  output logic [WORD_W-1:0] w_out
);
  localparam int NBYTES = WORD_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign w_out[8*b +: 8] = aes_kx_pkg::sbox8(w_in[8*b +: 8]);
  end
endmodule

// File: rtl/aes_kx_ctrl.sv
module aes_kx_ctrl #(
  parameter int CNT_W = 5,
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       key_size,
  output logic             accept,
  output logic             busy,
  output logic [1:0]       run_size,
  output logic [POS_W-1:0] pos,
  output logic [2:0]       half_nk,
  output logic             preload,
  output logic             full_step,
  output logic             sub_step,
  output logic             last
);
  import aes_kx_pkg::*;

  logic             busy_q, busy_d;
  logic [1:0]       size_q, size_d;
  logic [CNT_W-1:0] pair_q, pair_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             init_q, init_d;
  logic [CNT_W-1:0] total_pairs;
  logic             pos_wrap;

  always_comb begin
    unique case (size_q)
      KS_192:  begin half_nk = 3'd3; total_pairs = CNT_W'(26); end
      KS_256:  begin half_nk = 3'd4; total_pairs = CNT_W'(30); end
      default: begin half_nk = 3'd2; total_pairs = CNT_W'(22); end
    endcase
  end

  assign accept    = start && !busy_q && (key_size != KS_RSVD);
  assign pos_wrap  = ({1'b0, pos_q} == half_nk - 3'd1);
  assign last      = busy_q && (pair_q == total_pairs - CNT_W'(1));
  assign preload   = busy_q && init_q;
  assign full_step = busy_q && !init_q && (pos_q == '0);
  assign sub_step  = busy_q && !init_q && (size_q == KS_256) && (pos_q == POS_W'(2));

  always_comb begin
    busy_d = busy_q;
    size_d = size_q;
    pair_d = pair_q;
    pos_d  = pos_q;
    init_d = init_q;
    if (accept) begin
      busy_d = 1'b1;
      size_d = key_size;
      pair_d = '0;
      pos_d  = '0;
      init_d = 1'b1;
    end else if (busy_q) begin
      pair_d = pair_q + CNT_W'(1);
      pos_d  = pos_wrap ? '0 : pos_q + POS_W'(1);
      if (pos_wrap) init_d = 1'b0;
      if (last)     busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      size_q <= KS_128;
      pair_q <= '0;
      pos_q  <= '0;
      init_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      size_q <= size_d;
      pair_q <= pair_d;
      pos_q  <= pos_d;
      init_q <= init_d;
    end
  end

  assign busy     = busy_q;
  assign run_size = size_q;
  assign pos      = pos_q;
endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
  parameter int WORD_W = 32,
  parameter int MAX_NK = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             key_size,
  input  logic [WORD_W*MAX_NK-1:0] key_in,
  output logic [2*WORD_W-1:0]    kw_pair,
  output logic                   kw_valid,
  output logic                   kx_done
);
  localparam int KEY_W  = WORD_W * MAX_NK;
  localparam int PAIR_W = 2 * WORD_W;
  localparam int IDX_W  = $clog2(MAX_NK);
  localparam int POS_W  = $clog2(MAX_NK / 2);

  logic             accept, busy, preload, full_step, sub_step, last;
  logic [1:0]       run_size;
  logic [POS_W-1:0] pos;
  logic [2:0]       half_nk;

  aes_kx_ctrl #(.CNT_W(5), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .key_size(key_size),
    .accept(accept), .busy(busy), .run_size(run_size), .pos(pos),
    .half_nk(half_nk), .preload(preload), .full_step(full_step),
    .sub_step(sub_step), .last(last)
  );

  logic [KEY_W-1:0]  key_q, key_d;
  logic [WORD_W-1:0] hist_q [MAX_NK];
  logic [WORD_W-1:0] hist_d [MAX_NK];
  logic [7:0]        rcon_q, rcon_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic              valid_q, done_q;

  // Taps Nk and Nk-1 words back
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [WORD_W-1:0] tap_a, tap_b, newest, rot_w, sw_in, sw_out, temp_w;
  logic [WORD_W-1:0] w0, w1;
  logic [KEY_W-1:0]  key_sh;

  assign idx_a  = IDX_W'({half_nk, 1'b0} - 4'd1);
  assign idx_b  = IDX_W'({half_nk, 1'b0} - 4'd2);
  assign tap_a  = hist_q[idx_a];
  assign tap_b  = hist_q[idx_b];
  assign newest = hist_q[0];
  assign rot_w  = {newest[WORD_W-9:0], newest[WORD_W-1 -: 8]};
  assign sw_in  = full_step ? rot_w : newest;

  aes_kx_subword #(.WORD_W(WORD_W)) u_subword (.w_in(sw_in), .w_out(sw_out));

  always_comb begin
    if (full_step)     temp_w = sw_out ^ {rcon_q, {(WORD_W-8){1'b0}}};
    else if (sub_step) temp_w = sw_out;
    else               temp_w = newest;
    key_sh = key_q << (PAIR_W * int'(pos));
    if (preload) begin
      w0 = key_sh[KEY_W-1 -: WORD_W];
      w1 = key_sh[KEY_W-WORD_W-1 -: WORD_W];
    end else begin
      w0 = tap_a ^ temp_w;
      w1 = tap_b ^ w0;
    end
  end

  always_comb begin
    key_d  = key_q;
    rcon_d = rcon_q;
    pair_d = pair_q;
    for (int k = 0; k < MAX_NK; k++) hist_d[k] = hist_q[k];
    if (accept) begin
      key_d  = key_in;
      rcon_d = 8'h01;
    end else if (busy) begin
      pair_d    = {w0, w1};
      hist_d[0] = w1;
      hist_d[1] = w0;
      for (int k = 2; k < MAX_NK; k++) hist_d[k] = hist_q[k-2];
      if (full_step) rcon_d = aes_kx_pkg::xtime8(rcon_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      rcon_q  <= 8'h01;
      pair_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      for (int k = 0; k < MAX_NK; k++) hist_q[k] <= '0;
    end else begin
      key_q   <= key_d;
      rcon_q  <= rcon_d;
      pair_q  <= pair_d;
      valid_q <= busy && !accept;
      done_q  <= last;
      for (int k = 0; k < MAX_NK; k++) hist_q[k] <= hist_d[k];
    end
  end

  assign kw_pair  = pair_q;
  assign kw_valid = valid_q;
  assign kx_done  = done_q;
endmodule

// File: rtl/aes_key_expander_chk.sv
module aes_key_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] key_size,
  input logic       busy,
  input logic [1:0] run_size,
  input logic       kw_valid,
  input logic       kx_done
);
  logic [4:0] vcnt_q;
  logic [4:0] exp_last;
  logic       acc;

  assign acc = start && !busy && (key_size != 2'b11);

  always_comb begin
    unique case (run_size)
      2'b01:   exp_last = 5'd25;
      2'b10:   exp_last = 5'd29;
      default: exp_last = 5'd21;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vcnt_q <= '0;
    else if (acc)      vcnt_q <= '0;
    else if (kw_valid) vcnt_q <= vcnt_q + 5'd1;
  end

  p_first_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 kw_valid);
  p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kw_valid && !kx_done) |=> kw_valid);
  p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kx_done |-> kw_valid);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kx_done |=> !kx_done);
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(run_size));
  p_rsvd_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && key_size == 2'b11) |=> !busy);
  // R4, R5, R6: pair count per size
  p_pair_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kx_done |-> (vcnt_q == exp_last));
endmodule

bind aes_key_expander aes_key_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_size(key_size),
  .busy(busy), .run_size(run_size), .kw_valid(kw_valid), .kx_done(kx_done)
);

// File: tb/aes_key_expander_bench.sv
`timescale 1ns/1ps
module aes_key_expander_bench;
  localparam real HALF = 2.5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   key_size = 2'b00;
  logic [255:0] key_in = '0;
  logic [63:0]  kw_pair;
  logic         kw_valid;
  logic         kx_done;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  sb_t [256];
  logic [31:0] ref_w [60];

  always #(HALF) clk = ~clk;

  aes_key_expander u_aes_key_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .key_size(key_size),
    .key_in(key_in), .kw_pair(kw_pair), .kw_valid(kw_valid), .kx_done(kx_done)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [31:0] ref_sub(input logic [31:0] w);
    return {sb_t[w[31:24]], sb_t[w[23:16]], sb_t[w[15:8]], sb_t[w[7:0]]};
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (x != 0 && ref_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb_t[x] = s;
    end
  endtask

  task automatic ref_expand(input logic [255:0] key, input int nk);
    logic [7:0]  rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < nk; i++) ref_w[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nk+7); i++) begin
      t = ref_w[i-1];
      if (i % nk == 0) begin
        t = ref_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = ref_mul(rc, 8'h02);
      end else if (nk == 8 && i % 8 == 4) t = ref_sub(t);
      ref_w[i] = ref_w[i-nk] ^ t;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One run: inject_at >= 0 raises start with another size at that pair
  task automatic run_key(input logic [255:0] key, input logic [1:0] sz, input int inject_at);
    int nk = 4 + 2*int'(sz);
    int np = 2*(nk+7);
    string rq = (sz == 2'b00) ? "R4" : (sz == 2'b01) ? "R5" : "R6";
    ref_expand(key, nk);
    @(negedge clk); key_in = key; key_size = sz; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(kw_valid == 1'b0, "R3", {63'b0, kw_valid}, 64'd0);
    for (int p = 0; p < np; p++) begin
      @(negedge clk);
      start = 1'b0;
      check(kw_valid == 1'b1, "R3", {63'b0, kw_valid}, 64'd1);
      check(kw_pair == {ref_w[2*p], ref_w[2*p+1]},
            (p < nk/2) ? "R2" : (inject_at >= 0 && p > inject_at) ? "R8" : rq,
            kw_pair, {ref_w[2*p], ref_w[2*p+1]});
      check(kx_done == (p == np-1), "R7", {63'b0, kx_done}, {63'b0, p == np-1});
      if (p == inject_at) begin
        key_size = (sz == 2'b10) ? 2'b00 : 2'b10;
        key_in = ~key;
        start = 1'b1;
      end
    end
    @(negedge clk);
    check(kw_valid == 1'b0 && kx_done == 1'b0, "R7", {62'b0, kw_valid, kx_done}, 64'd0);
  endtask

  initial begin
    #(HALF*2*200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] keys [6];
    build_sbox();
    keys[0] = '0;
    keys[1] = '1;
    for (int i = 0; i < 32; i++) keys[2][255-8*i -: 8] = 8'(i);
    keys[3] = {8{32'hA5C3_0F1E}};
    keys[4] = {256'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    keys[5] = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    repeat (3) @(negedge clk);
    check(kw_valid == 1'b0 && kx_done == 1'b0, "R1", {62'b0, kw_valid, kx_done}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(kw_valid == 1'b0 && kx_done == 1'b0, "R1", {62'b0, kw_valid, kx_done}, 64'd0);

    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 6; k++)
        run_key(keys[k], 2'(s), (k == 3) ? 4 : (k == 1) ? 2*s + 3 : -1);

    // Published example keys and their final words
    ref_expand(keys[4], 4);
    check(ref_w[43] == 32'hb6630ca6, "R4", {32'b0, ref_w[43]}, 64'hb6630ca6);
    run_key(keys[4], 2'b00, -1);
    run_key({192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0}, 2'b01, -1);
    check(ref_w[51] == 32'h01002202, "R5", {32'b0, ref_w[51]}, 64'h01002202);
    run_key(keys[5], 2'b10, 9);
    check(ref_w[59] == 32'h706c631e, "R6", {32'b0, ref_w[59]}, 64'h706c631e);

    // R9: reserved size code from idle
    @(negedge clk); key_size = 2'b11; key_in = keys[2]; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      check(kw_valid == 1'b0 && kx_done == 1'b0, "R9", {62'b0, kw_valid, kx_done}, 64'd0);
      @(negedge clk);
    end
    run_key(keys[2], 2'b00, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule